// File: doc/BRIEF.md
# Command Stream Method Decoder

This block turns a flat stream of 32-bit command words into individual register writes. A header word opens a burst. It names a subchannel, a starting method address and the number of data words that follow. Each data word then leaves the block as one write that carries the subchannel, the method byte address and the data. After the last data word of a burst, the next word is read as a header.

Two header encodings are supported, and a static mode input picks one of them. The older encoding carries a byte method address and can mark a burst as incrementing or fixed-address. The newer encoding carries the method as a word index, which the block scales to a byte address. Writes leave through a registered valid/ready port. While that port is stalled, the decoder holds back the input stream, so no word is lost.

A write to method address 0 is flagged on its own output, because method 0 binds an object handle to the subchannel. A header that matches neither burst type sets a sticky error flag and is discarded.

Top module: `cmd_decoder`

## Requirements
- R1: With `fmt_new` low, a header carries the data word count in bits 29:18, the subchannel in bits 15:13 and the byte method address in bits 12:0. The first write of the burst uses that address unchanged, zero-extended to 15 bits.
- R2: A header with `fmt_new` low and bits 31:30 equal to 2'b00 opens an incrementing burst. Each further data word is written to the previous method address plus 4, wrapping modulo 2^15.
- R3: A header with `fmt_new` low and bits 31:30 equal to 2'b01 opens a fixed burst. Every data word of the burst is written to the same method address.
- R4: With `fmt_new` high, a header whose bits 31:29 equal 3'b001 opens an incrementing burst. It carries the count in bits 28:16, the subchannel in bits 15:13 and a word index in bits 12:0. The byte address written is the index times 4, and it advances by 4 per word.
- R5: The N data words that follow a header each produce exactly one write, in stream order, with the data unchanged. The word after them is decoded as a header.
- R6: A header whose count is zero produces no write, and the next word is decoded as a header.
- R7: A header that matches no burst type sets `err`. That means bits 31:30 equal to 2'b1x when `fmt_new` is low, or bits 31:29 other than 3'b001 when `fmt_new` is high. The word produces no write, the next word is decoded as a header, and `err` stays high until reset.
- R8: While `out_valid` is high and `out_ready` is low, the write outputs hold their values. Every data word accepted on the input appears exactly once on the output, whatever the stall pattern on either side.
- R9: `out_bind` is high together with a write exactly when that write's method byte address is 0.
- R10: After reset, `out_valid` and `err` are low and the first accepted word is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_new | input | 1 | Header encoding select, static between resets |
| in_valid | input | 1 | Command word present |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Command word accepted this cycle |
| out_valid | output | 1 | Write present |
| out_ready | input | 1 | Consumer takes the write |
| out_subch | output | 3 | Subchannel of the write |
| out_mthd | output | 15 | Method byte address of the write |
| out_data | output | 32 | Data of the write |
| out_bind | output | 1 | Write targets method 0 (object bind) |
| err | output | 1 | Sticky flag: an unrecognised header was seen |

## Verification
Two things can land in the same cycle: the output register handing its pending write to the consumer, and a new data word of the burst being accepted into that same register. The bench provokes this by running identical streams with an always-ready consumer, and again with periodic consumer stalls and input bubbles. Every write is compared in order against a list computed from the header fields. A dropped, duplicated or overwritten word therefore shows up as a mismatch or as a wrong final write count. A header arriving in the cycle its predecessor burst drains is covered by the back-to-back headers in the sweeps.

// File: rtl/cmd_decoder.sv
module cmd_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fmt_new,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [2:0]  out_subch,
  output logic [14:0] out_mthd,
  output logic [31:0] out_data,
  output logic        out_bind,
  output logic        err
);
  localparam int CW = 13;
  localparam int MW = 15;

  logic [CW-1:0] left_q;
  logic [MW-1:0] mthd_q;
  logic [2:0]    sub_q;
  logic          inc_q;

  wire in_burst = left_q != '0;
  wire out_free = !out_valid || out_ready;
  assign in_ready = !in_burst || out_free;

  wire hdr_fire = in_valid && in_ready && !in_burst;
  wire dat_fire = in_valid && in_ready && in_burst;

  wire          hdr_ok   = fmt_new ? (in_data[31:29] == 3'b001) : !in_data[31];
  wire          hdr_inc  = fmt_new ? 1'b1 : !in_data[30];
  wire [CW-1:0] hdr_cnt  = fmt_new ? in_data[28:16] : {1'b0, in_data[29:18]};
  wire [MW-1:0] hdr_mthd = fmt_new ? {in_data[12:0], 2'b00} : {2'b00, in_data[12:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q    <= '0;
      mthd_q    <= '0;
      sub_q     <= '0;
      inc_q     <= 1'b0;
      out_valid <= 1'b0;
      out_subch <= '0;
      out_mthd  <= '0;
      out_data  <= '0;
      out_bind  <= 1'b0;
      err       <= 1'b0;
    end else begin
      if (hdr_fire) begin
        if (hdr_ok) begin
          left_q <= hdr_cnt;
          mthd_q <= hdr_mthd;
          sub_q  <= in_data[15:13];
          inc_q  <= hdr_inc;
        end else begin
          err <= 1'b1;
        end
      end
      if (dat_fire) begin
        left_q    <= left_q - 1'b1;
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_mthd  <= mthd_q;
        out_subch <= sub_q;
        out_bind  <= (mthd_q == '0);
        if (inc_q) mthd_q <= mthd_q + MW'(4);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_mthd) && $stable(out_subch));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R7
  bad_hdr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire && !hdr_ok |=> !in_burst && err);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_fire |=> left_q == $past(left_q) - 1'b1);

  // R4
  new_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_new && out_valid |-> out_mthd[1:0] == 2'b00);
endmodule

// File: tb/tb_cmd_decoder.sv
module tb_cmd_decoder;
  localparam int CLK_P = 10;
  localparam int MAXW  = 512;
  localparam int LIMIT = 6000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        fmt_new = 0;
  logic        in_valid = 0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 0;
  logic [2:0]  out_subch;
  logic [14:0] out_mthd;
  logic [31:0] out_data;
  logic        out_bind;
  logic        err;

  cmd_decoder dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] words [MAXW];
  logic [2:0]  e_sub [MAXW];
  logic [14:0] e_m   [MAXW];
  logic [31:0] e_d   [MAXW];
  int nw, ne;
  int dseed = 1;

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic f);
    @(negedge clk);
    rst_n = 0; fmt_new = f; in_valid = 0; out_ready = 0;
    nw = 0; ne = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!out_valid, "R10 out_valid", 48'(out_valid), 0);
    chk(!err, "R10 err", 48'(err), 0);
    chk(in_ready, "R10 in_ready", 48'(in_ready), 1);
  endtask

  task automatic add_burst(input logic f, input int sub, input int m, input int n, input bit inc);
    logic [14:0] addr;
    if (f) begin
      words[nw] = {3'b001, 13'(n), 3'(sub), 13'(m)};
      addr = 15'(m * 4);
    end else begin
      words[nw] = {inc ? 2'b00 : 2'b01, 12'(n), 2'b00, 3'(sub), 13'(m)};
      addr = 15'(m);
    end
    nw++;
    for (int i = 0; i < n; i++) begin
      words[nw] = {16'(dseed), ~16'(dseed)};
      e_d[ne] = words[nw]; e_sub[ne] = 3'(sub); e_m[ne] = addr;
      if (inc) addr = addr + 15'd4;
      nw++; ne++; dseed++;
    end
  endtask

  task automatic add_raw(input logic [31:0] w);
    words[nw] = w; nw++;
  endtask

  task automatic run(input string tag, input int mode);
    int wi = 0, oi = 0, cyc = 0;
    bit pv = 0;
    logic [31:0] pd = '0;
    while ((oi < ne || wi < nw) && cyc < LIMIT) begin
      @(negedge clk);
      if (pv) chk(out_valid && out_data == pd, "R8 hold", 48'(out_data), 48'(pd));
      in_valid = (wi < nw) && !(mode > 0 && cyc % 4 == 3);
      in_data = in_valid ? words[wi] : '0;
      out_ready = (mode == 0) ? 1'b1 : (mode == 1 ? (cyc % 3 != 0) : (cyc % 7 >= 3));
      #1;
      pv = out_valid && !out_ready;
      pd = out_data;
      if (out_valid && out_ready) begin
        if (oi >= ne) chk(0, {tag, " extra write"}, 48'(oi), 48'(ne));
        else begin
          chk({out_subch, out_mthd, out_data} == {e_sub[oi], e_m[oi], e_d[oi]}, tag,
              {out_subch, out_mthd[12:0], out_data}, {e_sub[oi], e_m[oi][12:0], e_d[oi]});
          chk(out_bind == (e_m[oi] == 0), "R9 bind", 48'(out_bind), 48'(e_m[oi] == 0));
        end
        oi++;
      end
      if (in_valid && in_ready) wi++;
      cyc++;
    end
    if (cyc >= LIMIT) chk(0, {tag, " watchdog"}, 48'(cyc), LIMIT);
    @(negedge clk);
    in_valid = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    chk(!out_valid, {tag, " R5 drained"}, 48'(out_valid), 0);
    chk(oi == ne, {tag, " R5 count"}, 48'(oi), 48'(ne));
  endtask

  initial begin
    // R1 R2: legacy incrementing sweep over subchannel and count
    for (int mode = 0; mode < 3; mode++) begin
      do_reset(0);
      for (int s = 0; s < 8; s++)
        for (int n = 0; n < 4; n++)
          add_burst(0, s, (s == 0) ? 0 : s * 37 + n * 5, n, 1);
      run(mode == 0 ? "R1 legacy inc" : "R8 legacy inc stalled", mode);
    end
    // R3: legacy fixed-address sweep
    for (int mode = 0; mode < 3; mode++) begin
      do_reset(0);
      for (int s = 0; s < 8; s++)
        for (int n = 1; n < 4; n++)
          add_burst(0, s, (s == 3) ? 0 : 8191 - s * 11, n, 0);
      run("R3 legacy fixed", mode);
      chk(!err, "R3 no err", 48'(err), 0);
    end
    // R4: newer format sweep, including top index for wrap
    for (int mode = 0; mode < 3; mode++) begin
      do_reset(1);
      for (int s = 0; s < 8; s++)
        for (int n = 0; n < 4; n++)
          add_burst(1, s, (s == 1) ? 0 : (s == 7 ? 8191 : s * 101 + n), n, 1);
      run("R4 new inc", mode);
      chk(!err, "R4 no err", 48'(err), 0);
    end
    // R6: zero-count headers back to back
    do_reset(0);
    for (int k = 0; k < 5; k++) add_burst(0, k, 40 + k, 0, k % 2 == 0);
    add_burst(0, 5, 64, 2, 1);
    run("R6 zero count", 1);
    // R7: bad legacy header dropped, sticky
    do_reset(0);
    add_raw(32'h8008_2004);
    add_burst(0, 2, 12, 2, 1);
    run("R7 legacy bad", 0);
    chk(err, "R7 err set", 48'(err), 1);
    add_burst(0, 4, 0, 1, 0);
    run("R7 after err", 2);
    chk(err, "R7 err sticky", 48'(err), 1);
    // R7: bad new header (fixed-address pattern not supported)
    do_reset(1);
    add_raw(32'h6002_2003);
    add_burst(1, 6, 9, 3, 1);
    run("R7 new bad", 1);
    chk(err, "R7 new err", 48'(err), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule